// File: doc/BRIEF.md
# Video Register Write-Trap Controller

This block sits on an 8-bit I/O bus next to a CGA/MDA-compatible CRT controller. It watches host writes to the CRTC index and data ports, the mode control port and an operation control port. When trapping is armed, it holds back writes to protected registers, records a reason flag and raises a non-maskable interrupt request. A handler can then read the reason, program the real values itself and clear the request by reading the status port.

The block also keeps shadow copies of registers that the video hardware treats as write-only. Software can read back the last byte written to the mode port and the last byte written to the CRTC data port. The operation control register sets three things: whether NMIs are enabled, whether the protected registers are unlocked, and whether the adaptor is enabled. The NMI line is also gated by an external channel-check enable input. The bus has separate read and write address paths, so a posted write and a read can complete in the same cycle.

Top module: `vid_wtrap_ctrl`

## Requirements
- R1: After reset the status port (offset Dh) reads 00h, the mode port (offset 8h) reads 00h, `nmi_req` is low, `mode_out` is 00h, `adapt_en` is high and `crtc_sel` is 0.
- R2: A read of the mode port returns the last byte written to it, including bits that were held back from `mode_out`.
- R3: The last-data port (offset Fh) returns the last byte written to the CRTC data port, at either the colour alias (base 3D0h + 5) or, when `MONO_EN` is set, the mono alias (base 3B0h + 5).
- R4: When armed, a CRTC data write to an index whose bit is set in `PROT_MASK` sets status bit 5 and keeps `crtc_we` low. A write to an index whose bit is clear asserts `crtc_we` and sets no flag.
- R5: When armed, any mode port write sets status bit 7. `mode_out[5:0]` takes the written bits and `mode_out[7:6]` keeps its old value.
- R6: A write to the operation port (offset Eh) with bit 7 = 1 and bit 6 = 0 sets status bit 6, whatever the arming state was before.
- R7: Trapping is armed only while operation bit 7 = 1 and bit 6 = 0. Otherwise, writes set no flag, CRTC data writes assert `crtc_we`, and mode writes update all of `mode_out`.
- R8: A status read returns {bit7, bit6, bit5, 00000b} and clears the three flags at the end of that cycle.
- R9: `nmi_req` is a level equal to operation bit 7 AND `chan_chk_en` AND (any status flag set).
- R10: If a status read and a new trap event occur in the same cycle, the read returns the old flags and the new event's flag remains set afterwards.
- R11: `adapt_en` equals the inverse of operation bit 2.
- R12: A write to the CRTC index port (offset 4h) selects `crtc_sel` and is never trapped. Reads of unmapped addresses return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_waddr | input | ADDR_W | Write address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_raddr | input | ADDR_W | Read address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| chan_chk_en | input | 1 | External channel-check enable gating the NMI |
| nmi_req | output | 1 | Non-maskable interrupt request level |
| crtc_sel | output | IDX_W | Selected CRTC register index |
| crtc_we | output | 1 | Forwarded CRTC data write strobe |
| crtc_wdata | output | 8 | Data for the forwarded CRTC write |
| mode_out | output | 8 | Mode value applied to the video hardware |
| adapt_en | output | 1 | Adaptor enable |

## Verification
The bench builds the block with its default parameters: ADDR_W = 10, IDX_W = 5, colour base 3D0h, mono base 3B0h, MONO_EN = 1 and a protection mask covering indexes 0–3 and 6–11. With these values both data-port aliases can be reached, as can a protected index (0) and an unprotected index (0Eh). The directed scenarios cover a status read colliding with a mode trap in the same cycle, and NMI gating by both the channel-check input and operation bit 7.

// File: rtl/vid_wtrap_pkg.sv
package vid_wtrap_pkg;
   // port offsets from the adaptor base address
   localparam int OFS_IDX  = 4;
   localparam int OFS_DAT  = 5;
   localparam int OFS_MODE = 8;
   localparam int OFS_STAT = 13;
   localparam int OFS_OPC  = 14;
   localparam int OFS_LAST = 15;

   // operation control bit positions
   localparam int OPC_NMI_EN = 7;
   localparam int OPC_UNLOCK = 6;
   localparam int OPC_ADP_DIS = 2;

   typedef struct packed {
      logic idx;
      logic dat;
      logic mode;
      logic opc;
   } wr_hit_t;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_MODE = 2'd1,
      RD_STAT = 2'd2,
      RD_LAST = 2'd3
   } rd_sel_t;

   // reason flags, packed as status bits 7..5
   typedef struct packed {
      logic mode;
      logic opc;
      logic crtc;
   } reason_t;
endpackage

// File: rtl/vid_wtrap_decode.sv
module vid_wtrap_decode
   import vid_wtrap_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int COLOR_BASE = 'h3D0,
   parameter int MONO_BASE  = 'h3B0,
   parameter bit MONO_EN    = 1'b1
) (
   input  logic [ADDR_W-1:0] waddr,
   input  logic              wr,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              rd,
   output wr_hit_t           hit,
   output rd_sel_t           rsel,
   output logic              stat_rd
);
   localparam logic [ADDR_W-1:0] C_IDX  = ADDR_W'(COLOR_BASE + OFS_IDX);
   localparam logic [ADDR_W-1:0] C_DAT  = ADDR_W'(COLOR_BASE + OFS_DAT);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(COLOR_BASE + OFS_MODE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(COLOR_BASE + OFS_STAT);
   localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(COLOR_BASE + OFS_OPC);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(COLOR_BASE + OFS_LAST);

   logic mono_idx, mono_dat;

   generate
      if (MONO_EN) begin : g_mono
         localparam logic [ADDR_W-1:0] M_IDX = ADDR_W'(MONO_BASE + OFS_IDX);
         localparam logic [ADDR_W-1:0] M_DAT = ADDR_W'(MONO_BASE + OFS_DAT);
         assign mono_idx = (waddr == M_IDX);
         assign mono_dat = (waddr == M_DAT);
      end else begin : g_nomono
         assign mono_idx = 1'b0;
         assign mono_dat = 1'b0;
      end
   endgenerate

   assign hit.idx  = wr & ((waddr == C_IDX) | mono_idx);
   assign hit.dat  = wr & ((waddr == C_DAT) | mono_dat);
   assign hit.mode = wr & (waddr == A_MODE);
   assign hit.opc  = wr & (waddr == A_OPC);

   always_comb begin
      rsel = RD_NONE;
      if (rd) begin
         if (raddr == A_MODE)      rsel = RD_MODE;
         else if (raddr == A_STAT) rsel = RD_STAT;
         else if (raddr == A_LAST) rsel = RD_LAST;
      end
   end

   assign stat_rd = (rsel == RD_STAT);
endmodule

// File: rtl/vid_wtrap_policy.sv
module vid_wtrap_policy
   import vid_wtrap_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter logic [(1<<IDX_W)-1:0] PROT_MASK = 'h0FCF
) (
   input  wr_hit_t          hit,
   input  logic [7:0]       wdata,
   input  logic [IDX_W-1:0] idx,
   input  logic             armed,
   output reason_t          evt,
   output logic             crtc_we
);
   logic prot_idx;

   assign prot_idx  = PROT_MASK[idx];
   assign evt.crtc  = hit.dat & armed & prot_idx;
   assign evt.mode  = hit.mode & armed;
   assign evt.opc   = hit.opc & wdata[OPC_NMI_EN] & ~wdata[OPC_UNLOCK];
   assign crtc_we   = hit.dat & ~(armed & prot_idx);
endmodule

// File: rtl/vid_wtrap_regs.sv
module vid_wtrap_regs
   import vid_wtrap_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_hit_t          hit,
   input  logic [7:0]       wdata,
   output logic [IDX_W-1:0] idx_q,
   output logic [7:0]       mode_shadow,
   output logic [7:0]       mode_live,
   output logic [7:0]       last_dat,
   output logic [7:0]       opc_q,
   output logic             armed
);
   assign armed = opc_q[OPC_NMI_EN] & ~opc_q[OPC_UNLOCK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q       <= '0;
         mode_shadow <= '0;
         mode_live   <= '0;
         last_dat    <= '0;
         opc_q       <= '0;
      end else begin
         if (hit.idx) idx_q <= wdata[IDX_W-1:0];
         if (hit.dat) last_dat <= wdata;
         if (hit.opc) opc_q <= wdata;
         if (hit.mode) begin
            mode_shadow    <= wdata;
            mode_live[5:0] <= wdata[5:0];
            if (!armed) mode_live[7:6] <= wdata[7:6];
         end
      end
   end
endmodule

// File: rtl/vid_wtrap_status.sv
module vid_wtrap_status
   import vid_wtrap_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  reason_t evt,
   input  logic    stat_rd,
   input  logic    nmi_en,
   input  logic    chk_en,
   output reason_t flags,
   output logic    nmi
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (stat_rd ? reason_t'('0) : flags) | evt;
   end

   assign nmi = nmi_en & chk_en & (|flags);
endmodule

// File: rtl/vid_wtrap_ctrl.sv
module vid_wtrap_ctrl
   import vid_wtrap_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int IDX_W      = 5,
   parameter int COLOR_BASE = 'h3D0,
   parameter int MONO_BASE  = 'h3B0,
   parameter bit MONO_EN    = 1'b1,
   parameter logic [(1<<IDX_W)-1:0] PROT_MASK = 'h0FCF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_waddr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_raddr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   input  logic              chan_chk_en,
   output logic              nmi_req,
   output logic [IDX_W-1:0]  crtc_sel,
   output logic              crtc_we,
   output logic [7:0]        crtc_wdata,
   output logic [7:0]        mode_out,
   output logic              adapt_en
);
   generate
      if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_aw
         $error("vid_wtrap_ctrl: ADDR_W must be 10..16");
      end
      if (COLOR_BASE + 16 > (1 << ADDR_W) || MONO_BASE + 16 > (1 << ADDR_W)) begin : g_bad_base
         $error("vid_wtrap_ctrl: base address outside address space");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("vid_wtrap_ctrl: IDX_W must be 1..8");
      end
   endgenerate

   wr_hit_t          hit;
   rd_sel_t          rsel;
   logic             stat_rd;
   reason_t          evt, flags;
   logic             armed;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       mode_shadow, last_dat, opc_q;

   vid_wtrap_decode #(
      .ADDR_W(ADDR_W), .COLOR_BASE(COLOR_BASE),
      .MONO_BASE(MONO_BASE), .MONO_EN(MONO_EN)
   ) u_dec (
      .waddr(io_waddr), .wr(io_wr), .raddr(io_raddr), .rd(io_rd),
      .hit(hit), .rsel(rsel), .stat_rd(stat_rd)
   );

   vid_wtrap_regs #(.IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hit(hit), .wdata(io_wdata),
      .idx_q(idx_q), .mode_shadow(mode_shadow), .mode_live(mode_out),
      .last_dat(last_dat), .opc_q(opc_q), .armed(armed)
   );

   vid_wtrap_policy #(.IDX_W(IDX_W), .PROT_MASK(PROT_MASK)) u_pol (
      .hit(hit), .wdata(io_wdata), .idx(idx_q), .armed(armed),
      .evt(evt), .crtc_we(crtc_we)
   );

   vid_wtrap_status u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .stat_rd(stat_rd),
      .nmi_en(opc_q[OPC_NMI_EN]), .chk_en(chan_chk_en),
      .flags(flags), .nmi(nmi_req)
   );

   always_comb begin
      unique case (rsel)
         RD_MODE: io_rdata = mode_shadow;
         RD_STAT: io_rdata = {flags, 5'b0};
         RD_LAST: io_rdata = last_dat;
         default: io_rdata = 8'hFF;
      endcase
   end

   assign crtc_sel   = idx_q;
   assign crtc_wdata = io_wdata;
   assign adapt_en   = ~opc_q[OPC_ADP_DIS];
endmodule

// File: rtl/vid_wtrap_chk.sv
module vid_wtrap_chk #(
   parameter int ADDR_W     = 10,
   parameter int COLOR_BASE = 'h3D0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_waddr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_raddr,
   input logic              io_rd,
   input logic              chan_chk_en,
   input logic              nmi_req,
   input logic              crtc_we,
   input logic [7:0]        mode_out,
   input logic              adapt_en
);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(COLOR_BASE + 8);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(COLOR_BASE + 13);
   localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(COLOR_BASE + 14);

   assert_fwd_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      crtc_we |-> io_wr);

   assert_nmi_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_chk_en |-> !nmi_req);

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_raddr == A_STAT && !io_wr) |=> !nmi_req);

   assert_mode_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_waddr == A_MODE) |=> (mode_out[5:0] == $past(io_wdata[5:0])));

   assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_waddr == A_MODE) |=> $stable(mode_out));

   assert_opc_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_waddr == A_OPC && io_wdata[7:6] == 2'b10) |=> (nmi_req || !chan_chk_en));

   assert_adapt_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_waddr == A_OPC) |=> (adapt_en == !$past(io_wdata[2])));
endmodule

bind vid_wtrap_ctrl vid_wtrap_chk #(.ADDR_W(ADDR_W), .COLOR_BASE(COLOR_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_waddr(io_waddr), .io_wdata(io_wdata),
   .io_wr(io_wr), .io_raddr(io_raddr), .io_rd(io_rd),
   .chan_chk_en(chan_chk_en), .nmi_req(nmi_req), .crtc_we(crtc_we),
   .mode_out(mode_out), .adapt_en(adapt_en)
);

// File: tb/vid_wtrap_ctrl_tb_top.sv
module vid_wtrap_ctrl_tb_top;
   localparam int AW = 10;
   localparam logic [AW-1:0] P_CIDX = 10'h3D4, P_CDAT = 10'h3D5, P_MDAT = 10'h3B5;
   localparam logic [AW-1:0] P_MODE = 10'h3D8, P_STAT = 10'h3DD, P_OPC  = 10'h3DE;
   localparam logic [AW-1:0] P_LAST = 10'h3DF, P_NONE = 10'h3C0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] io_waddr = '0, io_raddr = '0;
   logic [7:0]    io_wdata = '0;
   logic          io_wr = 1'b0, io_rd = 1'b0, chan_chk_en = 1'b0;
   logic [7:0]    io_rdata, crtc_wdata, mode_out;
   logic          nmi_req, crtc_we, adapt_en;
   logic [4:0]    crtc_sel;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vid_wtrap_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .io_waddr(io_waddr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_raddr(io_raddr), .io_rd(io_rd), .io_rdata(io_rdata),
      .chan_chk_en(chan_chk_en), .nmi_req(nmi_req), .crtc_sel(crtc_sel),
      .crtc_we(crtc_we), .crtc_wdata(crtc_wdata), .mode_out(mode_out),
      .adapt_en(adapt_en)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output logic we);
      @(negedge clk);
      io_waddr = a; io_wdata = d; io_wr = 1'b1;
      #1 we = crtc_we;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      io_raddr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 nmi", {7'b0, nmi_req}, 8'h00);
      check("R1 mode_out", mode_out, 8'h00);
      check("R1 adapt_en", {7'b0, adapt_en}, 8'h01);
      check("R1 crtc_sel", {3'b0, crtc_sel}, 8'h00);
      rd(P_STAT, v); check("R1 status", v, 8'h00);
      rd(P_MODE, v); check("R1 mode read", v, 8'h00);
   endtask

   task automatic t_readback();
      logic [7:0] v; logic we;
      wr(P_MODE, 8'h29, we);
      rd(P_MODE, v);  check("R2 mode readback", v, 8'h29);
      check("R7 mode_out disarmed", mode_out, 8'h29);
      wr(P_CIDX, 8'h0E, we);
      check("R12 crtc_sel", {3'b0, crtc_sel}, 8'h0E);
      wr(P_CDAT, 8'h12, we);
      check("R7 crtc_we disarmed", {7'b0, we}, 8'h01);
      rd(P_LAST, v);  check("R3 last via colour", v, 8'h12);
      wr(P_MDAT, 8'h34, we);
      rd(P_LAST, v);  check("R3 last via mono", v, 8'h34);
      rd(P_NONE, v);  check("R12 unmapped read", v, 8'hFF);
      rd(P_STAT, v);  check("R7 no flags disarmed", v, 8'h00);
   endtask

   task automatic t_opc_trap();
      logic [7:0] v; logic we;
      chan_chk_en = 1'b1;
      wr(P_OPC, 8'h80, we);
      check("R9 nmi raised", {7'b0, nmi_req}, 8'h01);
      rd(P_STAT, v);  check("R6 opc flag", v, 8'h40);
      check("R8 nmi dropped", {7'b0, nmi_req}, 8'h00);
      rd(P_STAT, v);  check("R8 flags cleared", v, 8'h00);
      chan_chk_en = 1'b0;
      wr(P_OPC, 8'h80, we);
      check("R9 gated by chan_chk_en", {7'b0, nmi_req}, 8'h00);
      chan_chk_en = 1'b1;
      #1 check("R9 level follows chan_chk_en", {7'b0, nmi_req}, 8'h01);
      rd(P_STAT, v);  check("R6 flag kept while gated", v, 8'h40);
   endtask

   task automatic t_crtc_trap();
      logic [7:0] v; logic we;
      wr(P_CIDX, 8'h00, we);
      rd(P_STAT, v);  check("R12 index write not trapped", v, 8'h00);
      wr(P_CDAT, 8'h71, we);
      check("R4 protected not forwarded", {7'b0, we}, 8'h00);
      rd(P_STAT, v);  check("R4 crtc flag", v, 8'h20);
      wr(P_CIDX, 8'h0E, we);
      wr(P_CDAT, 8'h55, we);
      check("R4 unprotected forwarded", {7'b0, we}, 8'h01);
      rd(P_STAT, v);  check("R4 no flag unprotected", v, 8'h00);
   endtask

   task automatic t_mode_trap();
      logic [7:0] v; logic we;
      wr(P_MODE, 8'hC5, we);
      check("R5 protected bits held", mode_out, 8'h05);
      rd(P_MODE, v);  check("R2 readback after trap", v, 8'hC5);
      rd(P_STAT, v);  check("R5 mode flag", v, 8'h80);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      wr(P_OPC, 8'h80, v[0]);
      @(negedge clk);
      io_raddr = P_STAT; io_rd = 1'b1;
      io_waddr = P_MODE; io_wdata = 8'h01; io_wr = 1'b1;
      #1 check("R10 read sees old flags", io_rdata, 8'h40);
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
      check("R10 nmi held", {7'b0, nmi_req}, 8'h01);
      rd(P_STAT, v);  check("R10 new flag kept", v, 8'h80);
   endtask

   task automatic t_unlock();
      logic [7:0] v; logic we;
      wr(P_OPC, 8'hC0, we);
      wr(P_MODE, 8'hC5, we);
      check("R7 unlocked mode_out", mode_out, 8'hC5);
      wr(P_CIDX, 8'h01, we);
      wr(P_CDAT, 8'h28, we);
      check("R7 unlocked forward", {7'b0, we}, 8'h01);
      rd(P_STAT, v);  check("R7 unlocked no flags", v, 8'h00);
      wr(P_OPC, 8'h04, we);
      check("R11 adaptor disabled", {7'b0, adapt_en}, 8'h00);
      wr(P_OPC, 8'h00, we);
      check("R11 adaptor enabled", {7'b0, adapt_en}, 8'h01);
      wr(P_OPC, 8'h80, we);
      wr(P_OPC, 8'h40, we);
      check("R9 nmi off with bit7 clear", {7'b0, nmi_req}, 8'h00);
      rd(P_STAT, v);  check("R6 flag from earlier write", v, 8'h40);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_readback();
      t_opc_trap();
      t_crtc_trap();
      t_mode_trap();
      t_collide();
      t_unlock();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule